// File: doc/BRIEF.md
# Vector Compare to Predicate Mask Unit

This unit carries out a branch-style compare over register spans. A start pulse supplies two source register indices, a destination register index, a three-bit compare code and a vector length. A per-register length table decides whether each source is a vector or a scalar. The unit then compares one element pair per cycle and collects the outcomes into a bit mask, with one bit per element. At the end it writes the whole mask as one word into the destination integer register.

When neither source is a vector, the same operation acts as an ordinary conditional branch. The unit makes a single compare, does not write any register, and reports the outcome on `taken` together with `done`. The register file is outside the unit. The unit reads it through two combinational read ports and writes it through one write port.

Top module: `vcmp_mask_unit`

## Requirements
- R1: A source counts as a vector when its entry in `vecLenTab` (register r occupies bits [r*LENW +: LENW]) is greater than 1. An entry of 0 or 1 makes it a scalar.
- R2: In vector mode the effective length is `vlIn` clamped to XLEN. The unit compares one element per cycle and pulses `wrEn` in the cycle that follows the vlEff-th rising edge after the edge that accepted `start`.
- R3: For a vector source, element i is read from register (base+i) mod NREGS. A scalar source rereads its base register for every element.
- R4: Bit i of the written mask holds the compare result of element i. The mask is written in one write cycle to the destination index latched at start.
- R5: Compare codes are 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than and 111 unsigned greater-or-equal. Codes 010 and 011 always give false.
- R6: Mask bits at positions vlEff and above are written as 0. A vector operation with length 0 writes an all-zero mask at once.
- R7: When both sources are scalar, the unit makes one compare of the base registers and does not write. `done` rises one cycle after the first edge following the start edge, and `taken` carries the result. `taken` is low at all other times.
- R8: `done` is a single-cycle pulse that comes in the cycle directly after the mask write.
- R9: A `start` pulse that arrives while an operation is in progress is ignored.
- R10: After reset, `wrEn`, `done` and `taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| srcA | input | AW | First source register index |
| srcB | input | AW | Second source register index |
| dstIdx | input | AW | Destination register for the mask |
| cmpCode | input | 3 | Compare type |
| vlIn | input | LENW | Requested vector length |
| vecLenTab | input | NREGS*LENW | Per-register configured length table |
| rdAddrA | output | AW | Read port A address |
| rdDataA | input | XLEN | Read port A data (combinational) |
| rdAddrB | output | AW | Read port B address |
| rdDataB | input | XLEN | Read port B data (combinational) |
| wrEn | output | 1 | Mask write strobe |
| wrAddr | output | AW | Mask write address |
| wrData | output | XLEN | Mask write data |
| done | output | 1 | Operation complete pulse |
| taken | output | 1 | Branch decision, valid with done in scalar mode |

## Verification
The assertions assume that the register file returns read data in the same cycle as the address. They also assume that `vecLenTab`, `vlIn` and the operand fields are stable in the cycle `start` is sampled. The bench models the register file as a combinational array and changes table entries and register contents only between operations, at the falling edge. The random stimulus draws register values from a small pool part of the time so that equality compares occur. It also draws table lengths around 1 so that scalar, mixed and vector combinations all appear. Directed cases cover zero length, clamping above XLEN, index wraparound, undefined codes and a start pulse while busy.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  typedef struct packed {
    logic load;
    logic step;
  } strobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WRITE, ST_FIN} state_e;
endpackage

// File: rtl/vcmp_cmp.sv
module vcmp_cmp #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      code,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            hit
);
  import vcmp_pkg::*;
  logic isLtS, isLtU, isEq;

  always_comb begin
    isEq  = (opA == opB);
    isLtU = (opA < opB);
    isLtS = ($signed(opA) < $signed(opB));
    case (code)
      CMP_EQ:  hit = isEq;
      CMP_NE:  hit = !isEq;
      CMP_LT:  hit = isLtS;
      CMP_GE:  hit = !isLtS;
      CMP_LTU: hit = isLtU;
      CMP_GEU: hit = !isLtU;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcmp_dpath.sv
module vcmp_dpath #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int AW    = $clog2(NREGS),
  parameter int LENW  = $clog2(XLEN) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vcmp_pkg::strobes_t      stb,
  input  logic [AW-1:0]           srcA,
  input  logic [AW-1:0]           srcB,
  input  logic [AW-1:0]           dstIdx,
  input  logic [2:0]              cmpCode,
  input  logic [LENW-1:0]         vlIn,
  input  logic [NREGS*LENW-1:0]   vecLenTab,
  input  logic [XLEN-1:0]         rdDataA,
  input  logic [XLEN-1:0]         rdDataB,
  output logic [AW-1:0]           rdAddrA,
  output logic [AW-1:0]           rdAddrB,
  output logic [AW-1:0]           wrAddr,
  output logic [XLEN-1:0]         wrData,
  output logic                    takenQ,
  output logic                    bothScalarIn,
  output logic                    emptyIn,
  output logic                    lastElem
);
  localparam int IW = $clog2(XLEN);
  localparam logic [LENW-1:0] XLEN_L = LENW'(XLEN);

  logic [AW-1:0]   srcAQ, srcBQ, dstQ;
  logic [2:0]      codeQ;
  logic            vecAQ, vecBQ;
  logic [LENW-1:0] vlQ, idx, vlClamp;
  logic [XLEN-1:0] mask;
  logic            vecAIn, vecBIn, hit, branchQ;

  always_comb begin
    vecAIn       = vecLenTab[srcA*LENW +: LENW] > LENW'(1);
    vecBIn       = vecLenTab[srcB*LENW +: LENW] > LENW'(1);
    vlClamp      = (vlIn > XLEN_L) ? XLEN_L : vlIn;
    bothScalarIn = !vecAIn && !vecBIn;
    emptyIn      = (vlClamp == '0);
    branchQ      = !vecAQ && !vecBQ;
    lastElem     = (idx == vlQ - LENW'(1));
    rdAddrA      = srcAQ + (vecAQ ? AW'(idx) : '0);
    rdAddrB      = srcBQ + (vecBQ ? AW'(idx) : '0);
    wrAddr       = dstQ;
    wrData       = mask;
  end

  vcmp_cmp #(.XLEN(XLEN)) u_cmp (
    .code(codeQ), .opA(rdDataA), .opB(rdDataB), .hit(hit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAQ <= '0; srcBQ <= '0; dstQ <= '0; codeQ <= '0;
      vecAQ <= 1'b0; vecBQ <= 1'b0; vlQ <= '0; idx <= '0;
      mask <= '0; takenQ <= 1'b0;
    end else if (stb.load) begin
      srcAQ <= srcA; srcBQ <= srcB; dstQ <= dstIdx; codeQ <= cmpCode;
      vecAQ <= vecAIn; vecBQ <= vecBIn; vlQ <= vlClamp; idx <= '0;
      mask <= '0; takenQ <= 1'b0;
    end else if (stb.step) begin
      if (branchQ) takenQ <= hit;
      else         mask[idx[IW-1:0]] <= hit;
      idx <= idx + LENW'(1);
    end
  end

  // R2: a vector step never runs past the clamped length
  a_r2_step_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !branchQ) |-> (idx < vlQ));

  // R6: no mask bit at or above the length is ever set
  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (mask >> vlQ) == '0);
endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               bothScalarIn,
  input  logic               emptyIn,
  input  logic               lastElem,
  output vcmp_pkg::strobes_t stb,
  output logic               wrEn,
  output logic               done,
  output logic               branchMode
);
  import vcmp_pkg::*;
  state_e state, nextState;
  logic   branchQ;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.load  = 1'b1;
        nextState = (!bothScalarIn && emptyIn) ? ST_WRITE : ST_RUN;
      end
      ST_RUN: begin
        stb.step = 1'b1;
        if (branchQ)       nextState = ST_FIN;
        else if (lastElem) nextState = ST_WRITE;
      end
      ST_WRITE: nextState = ST_FIN;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign wrEn       = (state == ST_WRITE);
  assign done       = (state == ST_FIN);
  assign branchMode = branchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      branchQ <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.load) branchQ <= bothScalarIn;
    end
  end

  // R8: completion follows the mask write directly and lasts one cycle
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: a scalar compare finishes without any write
  a_r7_branch_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && branchQ) |=> (done && !wrEn));
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int AW    = $clog2(NREGS),
  parameter int LENW  = $clog2(XLEN) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [AW-1:0]         srcA,
  input  logic [AW-1:0]         srcB,
  input  logic [AW-1:0]         dstIdx,
  input  logic [2:0]            cmpCode,
  input  logic [LENW-1:0]       vlIn,
  input  logic [NREGS*LENW-1:0] vecLenTab,
  output logic [AW-1:0]         rdAddrA,
  input  logic [XLEN-1:0]       rdDataA,
  output logic [AW-1:0]         rdAddrB,
  input  logic [XLEN-1:0]       rdDataB,
  output logic                  wrEn,
  output logic [AW-1:0]         wrAddr,
  output logic [XLEN-1:0]       wrData,
  output logic                  done,
  output logic                  taken
);
  vcmp_pkg::strobes_t stb;
  logic takenQ, bothScalarIn, emptyIn, lastElem, branchMode;

  vcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bothScalarIn(bothScalarIn),
    .emptyIn(emptyIn), .lastElem(lastElem), .stb(stb), .wrEn(wrEn),
    .done(done), .branchMode(branchMode)
  );

  vcmp_dpath #(.XLEN(XLEN), .NREGS(NREGS), .AW(AW), .LENW(LENW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .srcA(srcA), .srcB(srcB),
    .dstIdx(dstIdx), .cmpCode(cmpCode), .vlIn(vlIn), .vecLenTab(vecLenTab),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData), .takenQ(takenQ),
    .bothScalarIn(bothScalarIn), .emptyIn(emptyIn), .lastElem(lastElem)
  );

  assign taken = done && branchMode && takenQ;

  // R7: the decision is only ever presented alongside completion
  a_r7_taken_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (done && !wrEn));
endmodule

// File: tb/test_vcmp_mask_unit.sv
module test_vcmp_mask_unit;
  localparam int XLEN = 32, NREGS = 32, AW = 5, LENW = 6;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [AW-1:0] srcA = '0, srcB = '0, dstIdx = '0;
  logic [2:0] cmpCode = '0;
  logic [LENW-1:0] vlIn = '0;
  logic [NREGS*LENW-1:0] vecLenTab = '0;
  logic [AW-1:0] rdAddrA, rdAddrB, wrAddr;
  logic [XLEN-1:0] rdDataA, rdDataB, wrData;
  logic wrEn, done, taken;
  logic [XLEN-1:0] regs [NREGS];
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
  always @(posedge clk) if (wrEn) regs[wrAddr] <= wrData;

  vcmp_mask_unit i_vcmp_mask_unit (
    .clk(clk), .rstN(rstN), .start(start), .srcA(srcA), .srcB(srcB),
    .dstIdx(dstIdx), .cmpCode(cmpCode), .vlIn(vlIn), .vecLenTab(vecLenTab),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .done(done), .taken(taken)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit cmpRef(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int lenOf(input int r);
    return int'(vecLenTab[r*LENW +: LENW]);
  endfunction

  task automatic setLen(input int r, input int len);
    vecLenTab[r*LENW +: LENW] = LENW'(len);
  endtask

  task automatic runOp(input int sa, input int sb, input int d, input logic [2:0] c,
                       input int vl, input bit poke);
    bit vecA, vecB, branch, expTaken;
    int vlE, wrCount, wrCyc, doneCyc, c0;
    logic [31:0] expMask, gotMask, gotTaken;
    logic [AW-1:0] gotAddr;
    vecA = lenOf(sa) > 1;   // R1
    vecB = lenOf(sb) > 1;
    branch = !vecA && !vecB;
    vlE = (vl > XLEN) ? XLEN : vl;
    expMask = '0;
    expTaken = cmpRef(c, regs[sa], regs[sb]);
    for (int i = 0; i < vlE; i++)   // R3 addressing, R4 bit order
      expMask[i] = cmpRef(c, regs[(sa + (vecA ? i : 0)) % NREGS],
                             regs[(sb + (vecB ? i : 0)) % NREGS]);
    @(negedge clk);
    srcA = AW'(sa); srcB = AW'(sb); dstIdx = AW'(d); cmpCode = c; vlIn = LENW'(vl);
    start = 1'b1;
    wrCount = 0; wrCyc = -1; doneCyc = -1; gotMask = '0; gotAddr = '0; gotTaken = '0;
    c0 = 0;
    while (c0 < 100) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && c0 == 0) begin  // R9 stimulus: start while busy
        start = 1'b1; dstIdx = AW'(d + 1);
      end
      if (wrEn) begin wrCount++; wrCyc = c0; gotMask = wrData; gotAddr = wrAddr; end
      if (!done) check(taken == 1'b0, "R7 taken low without done", {31'd0, taken}, 32'd0);
      if (done) begin doneCyc = c0; gotTaken = {31'd0, taken}; break; end
      c0++;
    end
    start = 1'b0;
    if (branch) begin
      check(wrCount == 0, "R7 no write in branch mode", wrCount, 0);
      check(doneCyc == 1, "R7 done timing", doneCyc, 1);
      check(gotTaken == {31'd0, expTaken}, "R7/R5 taken value", gotTaken, {31'd0, expTaken});
    end else begin
      check(wrCount == 1, "R4 single mask write", wrCount, 1);
      check(wrCyc == vlE, "R2 write cycle", wrCyc, vlE);
      check(gotAddr == AW'(d), "R4 destination", gotAddr, d);
      check(gotMask == expMask, "R4/R5/R6 mask value", gotMask, expMask);
      check(doneCyc == vlE + 1, "R8 done after write", doneCyc, vlE + 1);
      check(gotTaken == 0, "R7 taken low in vector mode", gotTaken, 0);
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done single pulse", {31'd0, done}, 0);
    check(wrEn == 1'b0, "R9 no extra operation", {31'd0, wrEn}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NREGS; r++) regs[r] = r * 7;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(wrEn == 0 && done == 0 && taken == 0, "R10 reset outputs",
          {29'd0, wrEn, done, taken}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(wrEn == 0 && done == 0, "R10 idle after reset", {30'd0, wrEn, done}, 0);

    // R7 scalar branch, equal and unequal (R1: entries 0 and 1 are scalar)
    setLen(3, 1); setLen(4, 0); regs[3] = 32'h55; regs[4] = 32'h55;
    runOp(3, 4, 9, 3'b000, 8, 1'b0);
    regs[4] = 32'h56;
    runOp(3, 4, 9, 3'b000, 8, 1'b0);
    // R5 signed vs unsigned
    regs[3] = 32'hFFFFFFFF; regs[4] = 32'h1;
    runOp(3, 4, 9, 3'b100, 1, 1'b0);
    runOp(3, 4, 9, 3'b110, 1, 1'b0);
    // R5 undefined code gives false
    regs[4] = 32'hFFFFFFFF;
    runOp(3, 4, 9, 3'b010, 1, 1'b0);
    // R6 zero length vector
    setLen(5, 4);
    runOp(5, 3, 10, 3'b001, 0, 1'b0);
    // R2/R6 clamp above XLEN: all elements equal
    for (int r = 0; r < NREGS; r++) regs[r] = 32'hABCD;
    setLen(0, 8); setLen(6, 1);
    runOp(0, 6, 6, 3'b000, 40, 1'b0);
    // R3 wraparound of the element index
    for (int r = 0; r < NREGS; r++) regs[r] = r;
    setLen(30, 4); setLen(7, 1);
    runOp(30, 7, 12, 3'b110, 4, 1'b0);
    // R9 start while busy is ignored
    runOp(30, 7, 12, 3'b011, 4, 1'b0);
    runOp(30, 7, 13, 3'b111, 5, 1'b1);

    // Random mix
    for (int k = 0; k < 200; k++) begin
      int sa, sb, d, vl;
      for (int r = 0; r < NREGS; r++)
        regs[r] = ($urandom % 3 == 0) ? ($urandom % 4) : $urandom;
      for (int r = 0; r < NREGS; r++)
        setLen(r, ($urandom % 2 == 0) ? ($urandom % 2) : 2 + $urandom % 30);
      sa = $urandom % NREGS; sb = $urandom % NREGS; d = $urandom % NREGS;
      vl = ($urandom % 8 == 0) ? 33 + $urandom % 30 : $urandom % 33;
      runOp(sa, sb, d, 3'($urandom), vl, ($urandom % 10 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule